// File: doc/BRIEF.md
# Match-Controlled Timer/Counter

This block is a free-running counter core of configurable width, driven by one clock. In timer mode it advances through a programmable prescaler on every clock cycle. In counter mode it advances on chosen transitions of an external input, which is synchronised and then sampled on every clock edge. A transition is found by comparing two consecutive samples of that input.

Four match registers are compared with the count value. Each match has its own three enable bits:

- raise a sticky interrupt flag,
- return the count to zero,
- freeze the count and drop the run enable.

Software programs the block through a flat register port. Register writes take effect at the next clock edge. Reads are combinational from the address.

Run control is a two-state machine:

- **RUN_IDLE**: the count and the prescaler hold.
- **RUN_ACTIVE**: the count and the prescaler advance.

It has three transitions:

- **start**: from RUN_IDLE, a control write with bit 0 set moves to RUN_ACTIVE.
- **soft halt**: from RUN_ACTIVE, a control write with bit 0 clear moves to RUN_IDLE.
- **match halt**: from RUN_ACTIVE, a stop-enabled match moves to RUN_IDLE. A control write in the same cycle takes precedence over a match halt.

Top module: `mtc_core`

## Requirements
- R1: After reset, all of the following are zero: the count, the prescale limit, the mode, the input select, the match control, all match values and all flags. The machine is in RUN_IDLE, so `run_o` and `irq_o` are 0.
- R2: Register addresses are as follows. 0 is control; a read returns the run state in bit 0. 1 is the count. 2 is the prescale limit. 3 is mode, with the mode in bits 1:0 and the input select in bits 3:2. 4 is match control. 5 is the flag register. 8 to 11 are the match values for matches 0 to 3. The mode, match control and match values read back as written.
- R3: In mode 00 (timer), while running, an increment slot occurs once every (prescale limit + 1) cycles. The count steps by one per slot, starting at the edge after start.
- R4: The external input passes through two synchronising flops. An event is found by comparing the current synchronised sample with the previous one. Mode 01 counts rising events, 10 counts falling events and 11 counts both. Each counted event is one prescaler tick. Levels held for two cycles are all counted.
- R5: Starting the counter while the external input is already high produces no event.
- R6: In counter mode, any input-select value other than 00 is reserved and selects no input. The count then stays unchanged.
- R7: A match i occurs on an increment slot whose current count equals match value i. If the interrupt enable of match i is set, flag bit i is set at that edge. `irq_o` is high while any flag is set, and `flag_o` shows the flags.
- R8: A reset-enabled match makes the count 0 at that slot, instead of the match value plus one.
- R9: A stop-enabled match keeps the count at the match value and returns the machine to RUN_IDLE. If reset and stop both fire, stop wins and the count holds.
- R10: Match-control bit layout: match i uses bit 3i for interrupt, 3i+1 for reset and 3i+2 for stop. Match 3 therefore uses bits 11, 10 and 9 for stop, reset and interrupt. Bits 31:12 read as 0.
- R11: Flags are sticky. Writing 1s to address 5 clears the matching flags. A flag set in the same cycle as a clear stays set.
- R12: In RUN_IDLE the count holds; only register writes change it. A control write with bit 1 set clears both the count and the prescaler, and bit 1 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| cap_i | input | 1 | External count input (asynchronous) |
| run_o | output | 1 | High in RUN_ACTIVE |
| irq_o | output | 1 | Any flag set |
| flag_o | output | 4 | Per-match sticky flags |

## Verification
The checker tests these properties on every cycle:

- The count holds in RUN_IDLE.
- In counter mode, the count moves only on a detected event.
- The count never moves by more than one step without a match.
- A reset match gives zero.
- A stop match drops the run state and freezes the count.
- Flags never clear without a write.

Some behaviour only the bench scenarios can show:

- The exact slot spacing under each prescale limit, and the count of edges per mode.
- The absence of a false event when starting with the input high, and that reserved selects count nothing.
- The interplay of random match settings, which is compared against a cycle model.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

    localparam int unsigned REG_AW = 4;

    localparam logic [REG_AW-1:0] A_CTRL = 4'd0;
    localparam logic [REG_AW-1:0] A_TC   = 4'd1;
    localparam logic [REG_AW-1:0] A_PRE  = 4'd2;
    localparam logic [REG_AW-1:0] A_MODE = 4'd3;
    localparam logic [REG_AW-1:0] A_MCTL = 4'd4;
    localparam logic [REG_AW-1:0] A_FLAG = 4'd5;
    localparam int unsigned       A_MR0  = 8;

    // per-match control field: interrupt, reset, stop (low to high)
    localparam int unsigned MF_IE   = 0;
    localparam int unsigned MF_RST  = 1;
    localparam int unsigned MF_STOP = 2;
    localparam int unsigned MF_W    = 3;

    typedef enum logic [1:0] {
        CM_TIMER = 2'b00,
        CM_RISE  = 2'b01,
        CM_FALL  = 2'b10,
        CM_BOTH  = 2'b11
    } cnt_mode_e;

    typedef enum logic [0:0] {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

endpackage

// File: rtl/mtc_cap_edge.sv
module mtc_cap_edge
    import mtc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cap_i,
    input  cnt_mode_e mode_i,
    input  logic [1:0] sel_i,
    output logic      tick_o
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   level;
    logic                   rise;
    logic                   fall;
    logic                   sel_ok;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= cap_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], cap_i};
            end
        end
    endgenerate

    assign level = sync_q[LAST];

    // previous sample always follows the synchronised level, so enabling
    // the counter never sees a stale level as an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise   = level & ~prev_q;
    assign fall   = ~level & prev_q;
    assign sel_ok = (sel_i == 2'b00);

    always_comb begin
        unique case (mode_i)
            CM_TIMER: tick_o = 1'b1;
            CM_RISE:  tick_o = sel_ok & rise;
            CM_FALL:  tick_o = sel_ok & fall;
            CM_BOTH:  tick_o = sel_ok & (rise | fall);
            default:  tick_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/mtc_prescale.sv
module mtc_prescale #(
    parameter int unsigned PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic [PW-1:0] limit_i,
    output logic          slot_o
);
    localparam logic [PW-1:0] PC_ONE = PW'(1);

    logic [PW-1:0] pc_q;

    assign slot_o = run_i & tick_i & (pc_q == limit_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               pc_q <= '0;
        else if (clear_i)         pc_q <= '0;
        else if (slot_o)          pc_q <= '0;
        else if (run_i && tick_i) pc_q <= pc_q + PC_ONE;
    end
endmodule

// File: rtl/mtc_match.sv
module mtc_match
    import mtc_pkg::*;
#(
    parameter int unsigned TW        = 32,
    parameter int unsigned NUM_MATCH = 4
) (
    input  logic [TW-1:0]             tc_i,
    input  logic [NUM_MATCH*TW-1:0]   mr_flat_i,
    input  logic [NUM_MATCH*MF_W-1:0] mctl_i,
    input  logic                      slot_i,
    output logic [NUM_MATCH-1:0]      irq_set_o,
    output logic                      rst_any_o,
    output logic                      stop_any_o
);
    logic [NUM_MATCH-1:0] hit;
    logic [NUM_MATCH-1:0] rst_v;
    logic [NUM_MATCH-1:0] stop_v;

    generate
        for (genvar g = 0; g < NUM_MATCH; g++) begin : g_cmp
            assign hit[g]       = slot_i && (tc_i == mr_flat_i[g*TW +: TW]);
            assign irq_set_o[g] = hit[g] & mctl_i[g*MF_W + MF_IE];
            assign rst_v[g]     = hit[g] & mctl_i[g*MF_W + MF_RST];
            assign stop_v[g]    = hit[g] & mctl_i[g*MF_W + MF_STOP];
        end
    endgenerate

    assign rst_any_o  = |rst_v;
    assign stop_any_o = |stop_v;
endmodule

// File: rtl/mtc_core.sv
module mtc_core
    import mtc_pkg::*;
#(
    parameter int unsigned TW          = 32,
    parameter int unsigned NUM_MATCH   = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [REG_AW-1:0]    addr_i,
    input  logic [TW-1:0]        wdata_i,
    output logic [TW-1:0]        rdata_o,
    input  logic                 cap_i,
    output logic                 run_o,
    output logic                 irq_o,
    output logic [NUM_MATCH-1:0] flag_o
);
    localparam int unsigned   MCW    = NUM_MATCH * MF_W;
    localparam logic [TW-1:0] TC_ONE = TW'(1);

    run_state_e           state_q, state_d;
    cnt_mode_e            mode_q;
    logic [1:0]           sel_q;
    logic [TW-1:0]        tc_q;
    logic [TW-1:0]        pre_q;
    logic [MCW-1:0]       mctl_q;
    logic [TW-1:0]        mr_q [NUM_MATCH];
    logic [NUM_MATCH*TW-1:0] mr_flat;
    logic [NUM_MATCH-1:0] flag_q;
    logic [NUM_MATCH-1:0] irq_set;
    logic                 rst_any;
    logic                 stop_any;
    logic                 tick;
    logic                 slot;
    logic                 running;

    logic ctrl_wr, tc_wr, pre_wr, mode_wr, mctl_wr, flag_wr, soft_clr;

    assign ctrl_wr  = wr_en_i && (addr_i == A_CTRL);
    assign tc_wr    = wr_en_i && (addr_i == A_TC);
    assign pre_wr   = wr_en_i && (addr_i == A_PRE);
    assign mode_wr  = wr_en_i && (addr_i == A_MODE);
    assign mctl_wr  = wr_en_i && (addr_i == A_MCTL);
    assign flag_wr  = wr_en_i && (addr_i == A_FLAG);
    assign soft_clr = ctrl_wr && wdata_i[1];
    assign running  = (state_q == RUN_ACTIVE);

    // ---------------- submodules ----------------
    mtc_cap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap_i),
        .mode_i (mode_q),
        .sel_i  (sel_q),
        .tick_o (tick)
    );

    mtc_prescale #(.PW(TW)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (soft_clr),
        .run_i   (running),
        .tick_i  (tick),
        .limit_i (pre_q),
        .slot_o  (slot)
    );

    generate
        for (genvar g = 0; g < NUM_MATCH; g++) begin : g_mrflat
            assign mr_flat[g*TW +: TW] = mr_q[g];
        end
    endgenerate

    mtc_match #(.TW(TW), .NUM_MATCH(NUM_MATCH)) u_match (
        .tc_i       (tc_q),
        .mr_flat_i  (mr_flat),
        .mctl_i     (mctl_q),
        .slot_i     (slot),
        .irq_set_o  (irq_set),
        .rst_any_o  (rst_any),
        .stop_any_o (stop_any)
    );

    // ---------------- run-control state machine ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_IDLE: begin
                if (ctrl_wr && wdata_i[0]) state_d = RUN_ACTIVE;       // start
            end
            RUN_ACTIVE: begin
                if (ctrl_wr)       state_d = wdata_i[0] ? RUN_ACTIVE : RUN_IDLE; // soft halt
                else if (stop_any) state_d = RUN_IDLE;                  // match halt
            end
            default: state_d = RUN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RUN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        run_o  = running;
        irq_o  = |flag_q;
        flag_o = flag_q;
    end

    // ---------------- count register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        tc_q <= '0;
        else if (soft_clr) tc_q <= '0;
        else if (tc_wr)    tc_q <= wdata_i;
        else if (slot) begin
            if (stop_any)     tc_q <= tc_q;
            else if (rst_any) tc_q <= '0;
            else              tc_q <= tc_q + TC_ONE;
        end
    end

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            mode_q <= CM_TIMER;
            sel_q  <= 2'b00;
            mctl_q <= '0;
        end else begin
            if (pre_wr)  pre_q <= wdata_i;
            if (mode_wr) begin
                mode_q <= cnt_mode_e'(wdata_i[1:0]);
                sel_q  <= wdata_i[3:2];
            end
            if (mctl_wr) mctl_q <= wdata_i[MCW-1:0];
        end
    end

    generate
        for (genvar g = 0; g < NUM_MATCH; g++) begin : g_mr
            localparam logic [REG_AW-1:0] MY_ADR = REG_AW'(A_MR0 + g);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                              mr_q[g] <= '0;
                else if (wr_en_i && (addr_i == MY_ADR))  mr_q[g] <= wdata_i;
            end
        end
    endgenerate

    // ---------------- sticky flags, set wins over clear ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else flag_q <= (flag_q & ~(flag_wr ? wdata_i[NUM_MATCH-1:0] : '0)) | irq_set;
    end

    // ---------------- read mux ----------------
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: rdata_o = {{(TW-1){1'b0}}, running};
            A_TC:   rdata_o = tc_q;
            A_PRE:  rdata_o = pre_q;
            A_MODE: rdata_o = {{(TW-4){1'b0}}, sel_q, mode_q};
            A_MCTL: rdata_o = {{(TW-MCW){1'b0}}, mctl_q};
            A_FLAG: rdata_o = {{(TW-NUM_MATCH){1'b0}}, flag_q};
            default: begin
                for (int i = 0; i < NUM_MATCH; i++) begin
                    if (addr_i == REG_AW'(A_MR0 + i)) rdata_o = mr_q[i];
                end
            end
        endcase
    end
endmodule

// File: rtl/mtc_core_chk.sv
module mtc_core_chk #(
    parameter int unsigned TW        = 32,
    parameter int unsigned NUM_MATCH = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en_i,
    input logic                 run_o,
    input logic [TW-1:0]        tc_q,
    input logic                 slot,
    input logic                 rst_any,
    input logic                 stop_any,
    input logic [NUM_MATCH-1:0] flag_q,
    input logic [1:0]           mode_q,
    input logic                 tick
);
    a_r12_idle_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !wr_en_i) |=> $stable(tc_q));

    a_r4_count_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 2'b00 && !tick && !wr_en_i) |=> $stable(tc_q));

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !wr_en_i && !rst_any && !stop_any)
        |=> (tc_q == $past(tc_q) || tc_q == $past(tc_q) + 1));

    a_r8_reset_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && rst_any && !stop_any && !wr_en_i) |=> (tc_q == '0));

    a_r9_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && stop_any && !wr_en_i) |=> (!run_o && $stable(tc_q)));

    a_r11_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

bind mtc_core mtc_core_chk #(.TW(TW), .NUM_MATCH(NUM_MATCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .run_o    (run_o),
    .tc_q     (tc_q),
    .slot     (slot),
    .rst_any  (rst_any),
    .stop_any (stop_any),
    .flag_q   (flag_q),
    .mode_q   (mode_q),
    .tick     (tick)
);

// File: tb/mtc_core_tb.sv
`timescale 1ns/1ps
module mtc_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        cap = 1'b0;
    logic        run;
    logic        irq;
    logic [3:0]  flags;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [3:0] RA_CTRL = 4'd0, RA_TC = 4'd1, RA_PRE = 4'd2,
                           RA_MODE = 4'd3, RA_MCTL = 4'd4, RA_FLAG = 4'd5;

    always #4 clk = ~clk;

    mtc_core u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap),
        .run_o(run), .irq_o(irq), .flag_o(flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulses(input int n, input int hi, input int lo);
        for (int k = 0; k < n; k++) begin
            cap = 1'b1; repeat (hi) @(negedge clk);
            cap = 1'b0; repeat (lo) @(negedge clk);
        end
    endtask

    task automatic cnt_case(input string tag, input logic [1:0] mode, input logic [1:0] sel,
                            input int pre, input int n, input int exp);
        logic [31:0] v;
        wr(RA_CTRL, 0);
        cap = 1'b0;
        repeat (4) @(negedge clk);
        wr(RA_MCTL, 0);
        wr(RA_PRE, pre);
        wr(RA_MODE, {28'd0, sel, mode});
        wr(RA_CTRL, 3);
        pulses(n, 2, 2);
        repeat (6) @(negedge clk);
        rd(RA_TC, v);
        chk(tag, v, exp);
    endtask

    // reference model state
    logic [31:0] m_tc;
    int          m_pc;
    bit          m_run;
    logic [3:0]  m_flags;

    task automatic model_step(input int pre, input logic [31:0] mr [4], input logic [11:0] mc);
        logic [3:0] hit;
        bit stp, rsv;
        if (m_run) begin
            if (m_pc == pre) begin
                stp = 0; rsv = 0;
                for (int i = 0; i < 4; i++) begin
                    hit[i] = (m_tc == mr[i]);
                    if (hit[i] && mc[3*i])   m_flags[i] = 1'b1;
                    if (hit[i] && mc[3*i+1]) rsv = 1;
                    if (hit[i] && mc[3*i+2]) stp = 1;
                end
                if (stp)      m_run = 0;
                else if (rsv) m_tc = 0;
                else          m_tc = m_tc + 1;
                m_pc = 0;
            end else begin
                m_pc++;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] mr [4];
        logic [11:0] mc;
        int pre;
        int mx;
        void'($urandom(32'd1234));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(RA_TC, v);   chk("R1 tc", v, 0);
        rd(RA_MCTL, v); chk("R1 mctl", v, 0);
        rd(8, v);       chk("R1 mr0", v, 0);
        chk("R1 run", run, 0);
        chk("R1 irq", irq, 0);

        // R2 / R10 register readback
        wr(4'd10, 32'h1234_5678); rd(4'd10, v); chk("R2 mr2", v, 32'h1234_5678);
        wr(RA_MODE, 32'hFF);      rd(RA_MODE, v); chk("R2 mode", v, 32'hF);
        wr(RA_MCTL, 32'hFFFF_FFFF); rd(RA_MCTL, v); chk("R10 mctl reserved", v, 32'hFFF);
        wr(RA_MODE, 0); wr(RA_MCTL, 0); wr(4'd10, 0);
        wr(RA_TC, 32'd77);
        wr(RA_CTRL, 2); rd(RA_CTRL, v); chk("R12 ctrl clear not stored", v, 0);
        rd(RA_TC, v); chk("R12 soft clear", v, 0);

        // R3 timer prescale
        wr(RA_PRE, 2);
        wr(RA_CTRL, 3);
        repeat (9) @(negedge clk);
        rd(RA_TC, v); chk("R3 prescale 2, 9 cycles", v, 3);
        rd(RA_CTRL, v); chk("R2 ctrl run readback", v, 1);
        wr(RA_CTRL, 0);
        rd(RA_TC, v);
        repeat (10) @(negedge clk);
        begin
            logic [31:0] v2;
            rd(RA_TC, v2); chk("R12 idle hold", v2, v);
        end

        // R4 counter modes, minimum two-cycle levels
        cnt_case("R4 rising", 2'b01, 2'b00, 0, 4, 4);
        cnt_case("R4 falling", 2'b10, 2'b00, 0, 4, 4);
        cnt_case("R4 both", 2'b11, 2'b00, 0, 4, 8);
        cnt_case("R4 both prescale 1", 2'b11, 2'b00, 1, 4, 4);
        cnt_case("R6 reserved select", 2'b11, 2'b01, 0, 4, 0);

        // R12 edges while idle
        wr(RA_MODE, 32'h3);
        wr(RA_CTRL, 2);
        pulses(3, 2, 2);
        repeat (5) @(negedge clk);
        rd(RA_TC, v); chk("R12 idle ignores edges", v, 0);

        // R5 no false edge at start
        wr(RA_MODE, 32'h1);
        cap = 1'b1;
        repeat (6) @(negedge clk);
        wr(RA_CTRL, 3);
        repeat (8) @(negedge clk);
        rd(RA_TC, v); chk("R5 start with input high", v, 0);
        cap = 1'b0; repeat (3) @(negedge clk);
        cap = 1'b1; repeat (6) @(negedge clk);
        rd(RA_TC, v); chk("R5 first real edge", v, 1);
        cap = 1'b0;

        // R9 / R10 / R7 stop on match 1
        wr(RA_CTRL, 0);
        wr(RA_MODE, 0); wr(RA_PRE, 0);
        wr(4'd9, 5);
        wr(RA_MCTL, 32'h28);  // bit5 stop, bit3 irq of match 1
        wr(RA_CTRL, 3);
        repeat (20) @(negedge clk);
        rd(RA_TC, v); chk("R9 stop holds at match", v, 5);
        chk("R9 stop clears run", run, 0);
        chk("R7 flag1", flags, 4'b0010);
        chk("R7 irq", irq, 1);
        wr(RA_FLAG, 32'h1);
        chk("R11 other bit clear keeps", flags, 4'b0010);
        wr(RA_FLAG, 32'h2);
        chk("R11 w1c", flags, 4'b0000);
        chk("R11 irq low", irq, 0);

        // R9 stop priority over reset on match 2
        wr(4'd10, 4);
        wr(RA_MCTL, 32'h180);  // bits 8 stop, 7 reset
        wr(RA_CTRL, 3);
        repeat (20) @(negedge clk);
        rd(RA_TC, v); chk("R9 stop beats reset", v, 4);
        chk("R9 run low", run, 0);

        // R8 reset on match 0 with interrupt
        wr(4'd10, 0);
        wr(8, 3);
        wr(RA_MCTL, 32'h3);
        wr(RA_CTRL, 3);
        mx = 0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            rd(RA_TC, v);
            if (int'(v) > mx) mx = int'(v);
        end
        chk("R8 wraps at match", mx, 3);
        chk("R8 flag0", flags[0], 1);
        wr(RA_CTRL, 0);
        wr(RA_FLAG, 32'hF);

        // constrained random timer runs against model (R3 R7 R8 R9 R10)
        for (int it = 0; it < 40; it++) begin
            pre = $urandom % 3;
            mc  = 12'($urandom);
            for (int i = 0; i < 4; i++) mr[i] = $urandom % 12;
            wr(RA_CTRL, 0);
            wr(RA_PRE, pre);
            wr(RA_MCTL, {20'd0, mc});
            for (int i = 0; i < 4; i++) wr(4'(8 + i), mr[i]);
            wr(RA_FLAG, 32'hF);
            wr(RA_CTRL, 3);
            m_tc = 0; m_pc = 0; m_run = 1; m_flags = 0;
            for (int c = 0; c < 40; c++) begin
                model_step(pre, mr, mc);
                @(negedge clk);
                rd(RA_TC, v);
                chk("R3/R8 random count", v, m_tc);
                chk("R9 random run", run, m_run);
                chk("R7/R10 random flags", flags, m_flags);
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule